// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Controller

This block decides, every clock, which of two decoded instructions may leave the decode stage of a two-wide superscalar core. It also tracks their results through three execution units of unequal latency: a single-cycle integer adder, a single-cycle multiplier and a two-cycle floating-point adder. Slot 0 always holds the older instruction and slot 1 the younger. The decoder keeps presenting an instruction until the controller reports it issued. It then shifts the younger one into slot 0.

Issue is strictly in program order. Completion is also in program order, and the block reports each result's destination register on one of two writeback ports in the cycle it retires. Pending writes are tracked with one busy bit per architectural register. Because nothing may issue or complete out of order, only read-after-write hazards need tracking. The arithmetic itself lives elsewhere. This block only produces the issue grants and the writeback timing.

Top module: `dual_issue_ctrl`

## Requirements
- R1: A valid slot-0 instruction is granted (`issue0` high) in the same cycle it is presented, provided no source is pending, no floating-point add issued in the previous cycle, and reset is released.
- R2: Slot 1 can be granted only in a cycle where slot 0 is granted. A valid slot 1 next to an invalid or stalled slot 0 stays waiting.
- R3: Unit codes are 0 = integer add, 1 = multiply, 2 = floating-point add. When both slots need the same unit, only slot 0 is granted.
- R4: An instruction whose source register has a write pending stalls. The pending mark is set at the clock edge that ends the issue cycle and cleared at the edge that ends the writeback cycle. A consumer of a single-cycle result can therefore issue two cycles after its producer, and a consumer of a floating-point add three cycles after.
- R5: Slot 1 is held back when it reads slot 0's destination, or writes the same destination as slot 0.
- R6: Register 0 as a source or destination never creates a dependency. A write to it still retires on a writeback port.
- R7: A single-cycle instruction retires in the cycle after it issues. A floating-point add retires two cycles after it issues.
- R8: In the cycle after a floating-point add issues, nothing issues. A floating-point add in slot 0 keeps slot 1 back in the same cycle.
- R9: Results retire in program order. When two retire together, port 0 carries the older one, and port 1 is never used without port 0.
- R10: While reset is low nothing is granted. After reset no writeback is reported and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in0_valid | input | 1 | Slot 0 (older) holds an instruction |
| in0_unit | input | 2 | Slot 0 unit code |
| in0_dst | input | REG_W | Slot 0 destination register |
| in0_srca | input | REG_W | Slot 0 first source register |
| in0_srcb | input | REG_W | Slot 0 second source register |
| in1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| in1_unit | input | 2 | Slot 1 unit code |
| in1_dst | input | REG_W | Slot 1 destination register |
| in1_srca | input | REG_W | Slot 1 first source register |
| in1_srcb | input | REG_W | Slot 1 second source register |
| issue0 | output | 1 | Slot 0 granted this cycle |
| issue1 | output | 1 | Slot 1 granted this cycle |
| wb0_valid | output | 1 | Older result retires this cycle |
| wb0_dst | output | REG_W | Destination of the older result |
| wb1_valid | output | 1 | Younger result retires this cycle |
| wb1_dst | output | REG_W | Destination of the younger result |

## Verification
The bench feeds short programs through a decoder-like queue.

- Independent pairs on different units show that dual grants and same-cycle retirement work.
- Same-unit pairs isolate the structural rule from the dependency rules.
- Producer-consumer chains across cycles and inside one pair tell the scoreboard timing apart from the pair comparison. The chains use both single-cycle and floating-point producers, so the two-cycle and three-cycle waits are told apart.
- Register-0 patterns show that the zero register is exempt.
- Floating-point adds in either slot separate the shadow stall from the ordering of the writeback ports.
- A lone valid slot 1 and a stalled slot 0 beside a ready slot 1 show that nothing is granted out of order.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
// Package: shared unit encoding for the dual-issue controller.
// Assumes the decoder delivers the 2-bit unit code unchanged.
package dis_pkg;

    typedef enum logic [1:0] {
        UNIT_IADD = 2'd0,
        UNIT_MUL  = 2'd1,
        UNIT_FADD = 2'd2,
        UNIT_RSVD = 2'd3
    } unit_e;

    // True for the unit whose result takes more than one cycle
    function automatic logic unit_is_multi(input unit_e u);
        return u == UNIT_FADD;
    endfunction

endpackage

// File: rtl/dis_scoreboard.sv
`timescale 1ns/1ps
// Module: dis_scoreboard
// One pending-write flag per architectural register. Flags are set by
// issue grants and cleared by writebacks; a set wins over a clear in the
// same cycle. Register 0 never holds a flag.
// Assumes at most two sets and two clears per cycle.
module dis_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                set_en,
    input  logic [1:0][REG_W-1:0]     set_reg,
    input  logic [1:0]                clr_en,
    input  logic [1:0][REG_W-1:0]     clr_reg,
    output logic [NUM_REGS-1:0]       busy
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign busy[g] = 1'b0;
        end else begin : g_live
            logic set_hit;
            logic clr_hit;
            logic flag_q;

            // Decode whether this register is written or retired now
            always_comb begin
                set_hit = (set_en[0] && set_reg[0] == REG_W'(g)) ||
                          (set_en[1] && set_reg[1] == REG_W'(g));
                clr_hit = (clr_en[0] && clr_reg[0] == REG_W'(g)) ||
                          (clr_en[1] && clr_reg[1] == REG_W'(g));
            end

            // Pending-write flag with set priority
            always_ff @(posedge clk) begin
                if (!rst_n)       flag_q <= 1'b0;
                else if (set_hit) flag_q <= 1'b1;
                else if (clr_hit) flag_q <= 1'b0;
            end

            assign busy[g] = flag_q;
        end
    end

    // R4
    set_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en[0] && set_reg[0] != '0 |=> busy[$past(set_reg[0])]);

    // R4
    retire_was_busy0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en[0] && clr_reg[0] != '0 |-> busy[clr_reg[0]]);

    // R4
    retire_was_busy1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en[1] && clr_reg[1] != '0 |-> busy[clr_reg[1]]);

endmodule

// File: rtl/dis_issue_select.sv
`timescale 1ns/1ps
// Module: dis_issue_select
// Combinational grant logic for two in-order slots. Slot 0 is the older
// instruction. Checks pending sources, the floating-add shadow cycle,
// unit clashes and dependencies inside the pair.
// Assumes the busy vector reflects writes still outstanding this cycle.
module dis_issue_select
    import dis_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                      enable,
    input  logic                      shadow,
    input  logic [NUM_REGS-1:0]       busy,
    input  logic [1:0]                valid,
    input  logic [1:0][1:0]           unit,
    input  logic [1:0][REG_W-1:0]     dst,
    input  logic [1:0][REG_W-1:0]     srca,
    input  logic [1:0][REG_W-1:0]     srcb,
    output logic [1:0]                issue
);

    logic [1:0] src_blk;
    logic       pair_raw;
    logic       pair_waw;
    logic       unit_clash;
    logic       first_multi;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        // A source stalls the slot when its register still awaits a write
        assign src_blk[s] = (srca[s] != '0 && busy[srca[s]]) ||
                            (srcb[s] != '0 && busy[srcb[s]]);
    end

    // Pair relations and final grants, oldest first
    always_comb begin
        pair_raw    = dst[0] != '0 && (srca[1] == dst[0] || srcb[1] == dst[0]);
        pair_waw    = dst[0] != '0 && dst[1] == dst[0];
        unit_clash  = unit[0] == unit[1];
        first_multi = unit_is_multi(unit_e'(unit[0]));
        issue[0]    = enable && valid[0] && !shadow && !src_blk[0];
        issue[1]    = issue[0] && valid[1] && !src_blk[1] && !pair_raw &&
                      !pair_waw && !unit_clash && !first_multi;
    end

endmodule

// File: rtl/dis_complete.sv
`timescale 1ns/1ps
// Module: dis_complete
// Tracks granted instructions to their writeback cycle. Single-cycle
// results retire one cycle after issue; floating adds retire two cycles
// after. Port 0 always carries the older result.
// Assumes the grant logic blocks all issue in the cycle after a floating
// add, so its retirement never meets a single-cycle retirement.
module dis_complete
    import dis_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                issue,
    input  logic [1:0][1:0]           unit,
    input  logic [1:0][REG_W-1:0]     dst,
    output logic [1:0]                wb_valid,
    output logic [1:0][REG_W-1:0]     wb_dst,
    output logic                      fadd_shadow
);

    logic [1:0]              a_v;
    logic [1:0][REG_W-1:0]   a_dst;
    logic                    f1_v, f2_v;
    logic [REG_W-1:0]        f1_dst, f2_dst;
    logic                    fadd_new;
    logic [REG_W-1:0]        fadd_dst;
    logic [1:0]              single_new;

    // Sort new grants into the short path and the floating-add path
    always_comb begin
        single_new[0] = issue[0] && !unit_is_multi(unit_e'(unit[0]));
        single_new[1] = issue[1] && !unit_is_multi(unit_e'(unit[1]));
        fadd_new      = 1'b0;
        fadd_dst      = '0;
        if (issue[0] && unit_is_multi(unit_e'(unit[0]))) begin
            fadd_new = 1'b1;
            fadd_dst = dst[0];
        end else if (issue[1] && unit_is_multi(unit_e'(unit[1]))) begin
            fadd_new = 1'b1;
            fadd_dst = dst[1];
        end
    end

    // Advance the retirement stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_v    <= '0;
            a_dst  <= '0;
            f1_v   <= 1'b0;
            f1_dst <= '0;
            f2_v   <= 1'b0;
            f2_dst <= '0;
        end else begin
            a_v    <= single_new;
            a_dst  <= dst;
            f1_v   <= fadd_new;
            f1_dst <= fadd_dst;
            f2_v   <= f1_v;
            f2_dst <= f1_dst;
        end
    end

    // Route retiring results onto ports, oldest on port 0
    always_comb begin
        wb_valid[0] = a_v[0] || f2_v;
        wb_dst[0]   = a_v[0] ? a_dst[0] : f2_dst;
        wb_valid[1] = a_v[1];
        wb_dst[1]   = a_dst[1];
        fadd_shadow = f1_v;
    end

    // R9
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_v[0] && f2_v));

    // R9
    port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid[1] |-> wb_valid[0]);

endmodule

// File: rtl/dual_issue_ctrl.sv
`timescale 1ns/1ps
// Module: dual_issue_ctrl
// Two-wide in-order issue and in-order completion control for an
// integer adder, a multiplier (both one cycle) and a two-cycle floating
// adder. Grants are combinational; writebacks come from registers.
// Assumes slot 0 is older than slot 1 and the decoder holds an
// instruction until it is granted.
module dual_issue_ctrl
    import dis_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in0_valid,
    input  logic [1:0]       in0_unit,
    input  logic [REG_W-1:0] in0_dst,
    input  logic [REG_W-1:0] in0_srca,
    input  logic [REG_W-1:0] in0_srcb,
    input  logic             in1_valid,
    input  logic [1:0]       in1_unit,
    input  logic [REG_W-1:0] in1_dst,
    input  logic [REG_W-1:0] in1_srca,
    input  logic [REG_W-1:0] in1_srcb,
    output logic             issue0,
    output logic             issue1,
    output logic             wb0_valid,
    output logic [REG_W-1:0] wb0_dst,
    output logic             wb1_valid,
    output logic [REG_W-1:0] wb1_dst
);

    logic [1:0]              valid_v;
    logic [1:0][1:0]         unit_v;
    logic [1:0][REG_W-1:0]   dst_v, srca_v, srcb_v;
    logic [1:0]              issue_v;
    logic [1:0]              wbv_v;
    logic [1:0][REG_W-1:0]   wbd_v;
    logic [NUM_REGS-1:0]     busy;
    logic                    shadow;

    // Gather slot fields into indexed bundles
    always_comb begin
        valid_v = {in1_valid, in0_valid};
        unit_v  = {in1_unit, in0_unit};
        dst_v   = {in1_dst, in0_dst};
        srca_v  = {in1_srca, in0_srca};
        srcb_v  = {in1_srcb, in0_srcb};
    end

    dis_scoreboard #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue_v),
        .set_reg (dst_v),
        .clr_en  (wbv_v),
        .clr_reg (wbd_v),
        .busy    (busy)
    );

    dis_issue_select #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_sel (
        .enable (rst_n),
        .shadow (shadow),
        .busy   (busy),
        .valid  (valid_v),
        .unit   (unit_v),
        .dst    (dst_v),
        .srca   (srca_v),
        .srcb   (srcb_v),
        .issue  (issue_v)
    );

    dis_complete #(.REG_W(REG_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue_v),
        .unit        (unit_v),
        .dst         (dst_v),
        .wb_valid    (wbv_v),
        .wb_dst      (wbd_v),
        .fadd_shadow (shadow)
    );

    assign issue0    = issue_v[0];
    assign issue1    = issue_v[1];
    assign wb0_valid = wbv_v[0];
    assign wb0_dst   = wbd_v[0];
    assign wb1_valid = wbv_v[1];
    assign wb1_dst   = wbd_v[1];

    // R7
    short_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue0 && in0_unit != 2'(UNIT_FADD) |=> wb0_valid && wb0_dst == $past(in0_dst));

    // R7
    long_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue0 && in0_unit == 2'(UNIT_FADD), 2) |-> wb0_valid && wb0_dst == $past(in0_dst, 2));

    // R9
    young_fadd_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue1 && in1_unit == 2'(UNIT_FADD), 2) |-> wb0_valid && !wb1_valid);

    // R8
    fadd_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && in0_unit == 2'(UNIT_FADD)) || (issue1 && in1_unit == 2'(UNIT_FADD)) |=> !issue0);

endmodule

// File: tb/dual_issue_ctrl_tb.sv
`timescale 1ns/1ps
module dual_issue_ctrl_tb;
    localparam int NREG = 32;
    localparam int RW   = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic v0, v1;
    logic [1:0] u0, u1;
    logic [RW-1:0] d0, a0, b0, d1, a1, b1;
    logic issue0, issue1, wb0_valid, wb1_valid;
    logic [RW-1:0] wb0_dst, wb1_dst;

    dual_issue_ctrl #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(v0), .in0_unit(u0), .in0_dst(d0), .in0_srca(a0), .in0_srcb(b0),
        .in1_valid(v1), .in1_unit(u1), .in1_dst(d1), .in1_srca(a1), .in1_srcb(b1),
        .issue0(issue0), .issue1(issue1),
        .wb0_valid(wb0_valid), .wb0_dst(wb0_dst),
        .wb1_valid(wb1_valid), .wb1_dst(wb1_dst)
    );

    typedef struct { int due; int dst; int seq; } rec_t;
    typedef struct { int u; int d; int a; int b; } ins_t;
    rec_t  pend[$];
    ins_t  prog[$];
    int    wb_at [NREG];
    int    cyc, last_fadd, seq_n;
    bit    e0, e1, sh, seen_edge, done;
    int    n_chk, n_fail, cnt, x0, x1;
    string cur_tag;

    function automatic bit busy_m(int r);
        return (r != 0) && (wb_at[r] >= cyc);
    endfunction

    task automatic chk(string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", cur_tag, what, got, exp);
        end
    endtask

    task automatic note(int u, int d);
        int lat = (u == 2) ? 2 : 1;
        pend.push_back('{cyc + lat, d, seq_n});
        seq_n++;
        if (d != 0) wb_at[d] = cyc + lat;
        if (u == 2) last_fadd = cyc;
    endtask

    // Reference: expected grants and retirements, compared every cycle
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            if (!rst_n) begin
                e0 = 1'b0; e1 = 1'b0;
            end else begin
                sh = (last_fadd == cyc - 1);
                e0 = v0 && !sh && !busy_m(int'(a0)) && !busy_m(int'(b0));
                e1 = e0 && v1 && !busy_m(int'(a1)) && !busy_m(int'(b1)) &&
                     !(d0 != 0 && (a1 == d0 || b1 == d0 || d1 == d0)) &&
                     (u1 != u0) && (u0 != 2'd2);
            end
            chk("issue0", int'(issue0), int'(e0));
            chk("issue1", int'(issue1), int'(e1));
            cnt = 0; x0 = 0; x1 = 0;
            foreach (pend[i]) begin
                if (pend[i].due == cyc) begin
                    if (cnt == 0) x0 = pend[i].dst; else x1 = pend[i].dst;
                    cnt++;
                end
            end
            chk("wb0_valid", int'(wb0_valid), int'(cnt >= 1));
            if (cnt >= 1) chk("wb0_dst", int'(wb0_dst), x0);
            chk("wb1_valid", int'(wb1_valid), int'(cnt >= 2));
            if (cnt >= 2) chk("wb1_dst", int'(wb1_dst), x1);
        end
    end

    // Reference state advance at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            for (int i = 0; i < NREG; i++) wb_at[i] = -1;
            cyc = 0;
            last_fadd = -10;
        end else begin
            if (e0) note(int'(u0), int'(d0));
            if (e1) note(int'(u1), int'(d1));
            cyc++;
            while (pend.size() > 0 && pend[0].due < cyc) void'(pend.pop_front());
        end
        seen_edge = 1'b1;
    end

    task automatic idle();
        v0 = 0; v1 = 0; u0 = 0; u1 = 0;
        d0 = 0; a0 = 0; b0 = 0; d1 = 0; a1 = 0; b1 = 0;
    endtask

    task automatic add(int u, int d, int a, int b);
        prog.push_back('{u, d, a, b});
    endtask

    // Present the program like a decoder, advancing by the expected grants
    task automatic run_prog(string tag);
        int head = 0;
        int guard = 0;
        cur_tag = tag;
        while (head < prog.size() && guard < 100) begin
            v0 = 1; u0 = 2'(prog[head].u); d0 = RW'(prog[head].d);
            a0 = RW'(prog[head].a); b0 = RW'(prog[head].b);
            if (head + 1 < prog.size()) begin
                v1 = 1; u1 = 2'(prog[head+1].u); d1 = RW'(prog[head+1].d);
                a1 = RW'(prog[head+1].a); b1 = RW'(prog[head+1].b);
            end else begin
                v1 = 0; u1 = 0; d1 = 0; a1 = 0; b1 = 0;
            end
            @(posedge clk); #1;
            head += int'(e0) + int'(e1);
            guard++;
        end
        if (guard >= 100) begin
            n_fail++;
            $display("FAIL %s program stuck: got head %0d expected %0d", tag, head, prog.size());
        end
        idle();
        repeat (4) @(posedge clk);
        #1;
        prog.delete();
    endtask

    task automatic report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #250000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        n_chk = 0; n_fail = 0; seq_n = 0; done = 0; seen_edge = 0;
        e0 = 0; e1 = 0; cur_tag = "R10";
        idle();
        rst_n = 0;
        for (int i = 0; i < NREG; i++) wb_at[i] = -1;
        // R10: grants held off while reset is low, even with a valid slot
        repeat (2) @(posedge clk);
        #1; v0 = 1; u0 = 0; d0 = 3; a0 = 1; b0 = 2;
        @(negedge clk);
        chk("issue0 in reset", int'(issue0), 0);
        chk("wb0_valid in reset", int'(wb0_valid), 0);
        @(posedge clk); #1;
        idle();
        rst_n = 1;
        // R10: no pending register after reset, reader of r7 issues at once
        add(0, 5, 7, 8);
        run_prog("R10");

        // R1: lone independent instructions
        add(0, 1, 2, 3);
        run_prog("R1");
        add(1, 4, 6, 7);
        run_prog("R1");

        // R3: unit clashes and a clean pair
        add(1, 4, 2, 3); add(1, 5, 6, 7);
        run_prog("R3");
        add(0, 6, 2, 3); add(0, 7, 8, 9);
        run_prog("R3");
        add(0, 8, 2, 3); add(1, 9, 4, 5);
        run_prog("R3");

        // R5: dependency and shared destination inside a pair
        add(0, 5, 1, 2); add(1, 6, 5, 3);
        run_prog("R5");
        add(0, 9, 1, 2); add(1, 9, 3, 4);
        run_prog("R5");
        add(0, 10, 1, 2); add(1, 11, 3, 10);
        run_prog("R5");

        // R4: waits on single-cycle and floating producers
        add(1, 10, 1, 2); add(0, 11, 3, 4); add(0, 12, 10, 11);
        run_prog("R4");
        add(2, 13, 1, 2); add(0, 14, 13, 1);
        run_prog("R4");
        add(0, 15, 1, 2); add(1, 16, 3, 4); add(2, 17, 15, 16); add(0, 18, 17, 17);
        run_prog("R4");

        // R6: register zero is exempt from dependencies
        add(0, 0, 1, 2); add(1, 3, 0, 0);
        run_prog("R6");
        add(0, 0, 1, 2); add(1, 0, 3, 4); add(0, 7, 0, 0);
        run_prog("R6");

        // R8: floating add blocks its partner and the next cycle
        add(2, 15, 1, 2); add(0, 16, 3, 4);
        run_prog("R8");
        add(2, 17, 1, 2); add(2, 18, 3, 4); add(1, 19, 5, 6);
        run_prog("R8");

        // R7 and R9: mixed latencies retire in program order
        add(0, 19, 1, 2); add(2, 20, 3, 4); add(1, 21, 5, 6);
        run_prog("R7");
        add(0, 22, 1, 2); add(1, 23, 3, 4); add(2, 24, 5, 6); add(0, 25, 7, 8);
        run_prog("R9");
        add(2, 12, 13, 14); add(0, 1, 8, 9); add(1, 4, 2, 3);
        add(1, 5, 6, 7); add(0, 10, 5, 7); add(0, 11, 2, 3);
        run_prog("R9");

        // R2: lone slot 1 must not be granted
        cur_tag = "R2";
        v0 = 0; v1 = 1; u1 = 0; d1 = 3; a1 = 1; b1 = 2;
        @(negedge clk);
        chk("issue1 with empty slot 0", int'(issue1), 0);
        @(posedge clk); #1;
        idle();
        repeat (2) @(posedge clk);
        #1;
        // R2: stalled slot 0 keeps a ready slot 1 waiting
        add(0, 21, 1, 2); add(1, 22, 21, 3); add(0, 23, 4, 5);
        run_prog("R2");

        repeat (3) @(posedge clk);
        #1;
        report();
    end
endmodule